// File: doc/BRIEF.md
# Region Protection Unit

This block checks every processor access against a small set of programmable address regions and decides, in the same cycle, whether the access may proceed. Instruction fetches and data accesses are checked independently, each against its own bank of regions. A region is a base address with a power-of-two size from 4 KB to 16 MB. Each region carries an enable, an access-permitted bit, a speculation-permitted bit, a read-only bit and a supervisor-only bit. An address that falls in none of the enabled regions of its side takes the attributes of one global default entry, which both sides share.

For each access the unit gives exactly one of three outcomes. The access is granted, or it raises a protection fault, or it is held as a stall when it is speculative and targets memory that forbids speculation. The unit also reports whether a region matched, which region won, and the attribute bits it applied. Region and default registers are loaded through a write-only configuration port. A write takes effect on the access checks from the next cycle.

Top module: `mprot_unit`

## Requirements
- R1: After reset every region is disabled and the default entry permits access and speculation, so any access on either side reports ok with no region hit and attribute output 4'b0011.
- R2: Size code c selects a region of 4 KB shifted left by c (c = 0 is 4 KB, c = 12 is 16 MB). An address matches when its bits at and above position 12+c equal the base's. Codes above 12 act as 12.
- R3: Base address bits below the region size are ignored, so a misaligned base behaves as the aligned base below it.
- R4: A region whose enable bit (cfg_attr bit 4) is clear never matches.
- R5: When several enabled regions of one side match, the lowest-numbered one is applied and its number appears on the index output.
- R6: An access that matches no region uses the default entry (written with cfg_sel = 4, shared by both sides), reports hit low and index 0.
- R7: Writes with cfg_dside = 1 load data regions and with cfg_dside = 0 load instruction regions; neither set affects the other side's checks.
- R8: An access whose applied attributes have the allow bit (bit 0) clear reports a fault.
- R9: A data write (d_wr = 1) to memory whose applied read-only bit (bit 2) is set reports a fault.
- R10: A data user access (d_user = 1) to memory whose applied supervisor-only bit (bit 3) is set reports a fault.
- R11: The instruction side applies no read-only or supervisor-only check.
- R12: A speculative access without a fault, to memory whose speculation bit (bit 1) is clear, reports stall rather than ok or fault. The same access issued non-speculatively reports ok. A fault takes precedence over a stall.
- R13: Outcome, hit, index and attributes are combinational in the current access. With valid high, exactly one of ok, stall and fault is high. With valid low, ok, stall, fault and hit are all low.
- R14: A configuration write is applied at the clock edge on which cfg_we is high and affects checks from then on, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dside | input | 1 | 1 selects data regions, 0 instruction regions |
| cfg_sel | input | 3 | Region number 0-3, or 4 for the shared default entry |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 4 | Size code |
| cfg_attr | input | 5 | {enable, supervisor-only, read-only, speculation ok, allow} |
| i_vld | input | 1 | Instruction fetch valid |
| i_addr | input | 32 | Fetch address |
| i_spec | input | 1 | Fetch is speculative |
| i_ok | output | 1 | Fetch granted |
| i_stall | output | 1 | Fetch held until non-speculative |
| i_fault | output | 1 | Fetch protection fault |
| i_hit | output | 1 | A fetch region matched |
| i_idx | output | 2 | Winning fetch region |
| i_attr | output | 4 | Applied fetch attributes |
| d_vld | input | 1 | Data access valid |
| d_addr | input | 32 | Data address |
| d_wr | input | 1 | Access is a write |
| d_user | input | 1 | Access is in user mode |
| d_spec | input | 1 | Access is speculative |
| d_ok | output | 1 | Data access granted |
| d_stall | output | 1 | Data access held until non-speculative |
| d_fault | output | 1 | Data protection fault |
| d_hit | output | 1 | A data region matched |
| d_idx | output | 2 | Winning data region |
| d_attr | output | 4 | Applied data attributes |

## Verification
The decision path is combinational, so a corrupted base, size code or enable bit shows up on hit, index and outcome in the first access to an affected address. A stale register shows in the cycle right after the write. A wrong priority chain shows only where regions overlap, so the vectors place nested regions around the same addresses. Attribute or decision faults show as the wrong outcome, or as two outcomes at once, on the very access that uses those attributes.

// File: rtl/mprot_pkg.sv
package mprot_pkg;
   // positions inside the applied attribute nibble
   localparam int unsigned AT_ALLOW = 0;
   localparam int unsigned AT_SPEC  = 1;
   localparam int unsigned AT_RO    = 2;
   localparam int unsigned AT_SV    = 3;
   // extra bit carried only in the configuration word
   localparam int unsigned AT_EN    = 4;
   localparam int unsigned ATW      = 4;
   localparam int unsigned CFGW     = 5;

   typedef logic [ATW-1:0]  attr_t;
   typedef logic [CFGW-1:0] cfg_attr_t;

   typedef struct packed {
      logic ok;
      logic stall;
      logic fault;
   } verdict_t;
endpackage

// File: rtl/mprot_region.sv
module mprot_region
   import mprot_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned MIN_SHIFT = 12,
   parameter int unsigned MAX_CODE  = 12,
   parameter int unsigned SZW       = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [AW-1:0]  base_in,
   input  logic [SZW-1:0] size_in,
   input  cfg_attr_t      attr_in,
   input  logic [AW-1:0]  addr,
   output logic           match,
   output attr_t          attr_o
);
   logic [AW-1:0]  base_q;
   logic [SZW-1:0] code_q;
   cfg_attr_t      cfg_q;
   logic [SZW-1:0] code_eff;
   logic [AW-1:0]  care;

   // codes beyond the largest size collapse onto it
   assign code_eff = (size_in > SZW'(MAX_CODE)) ? SZW'(MAX_CODE) : size_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         code_q <= '0;
         cfg_q  <= '0;
      end else if (we) begin
         base_q <= base_in;
         code_q <= code_eff;
         cfg_q  <= attr_in;
      end
   end

   // only bits at or above the region size take part in the compare
   always_comb begin
      for (int b = 0; b < int'(AW); b++)
         care[b] = (b >= int'(MIN_SHIFT) + int'(code_q));
   end

   assign match  = cfg_q[AT_EN] && (((addr ^ base_q) & care) == '0);
   assign attr_o = cfg_q[ATW-1:0];

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !attr_in[AT_EN]) |=> !match); // R4
endmodule

// File: rtl/mprot_prio.sv
module mprot_prio #(
   parameter int unsigned N    = 4,
   parameter int unsigned IDXW = 2
) (
   input  logic [N-1:0]    req,
   output logic [N-1:0]    grant,
   output logic            any,
   output logic [IDXW-1:0] idx
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar k = 0; k < N; k++) begin : g_chain
      assign grant[k]     = req[k] & ~blocked[k];
      assign blocked[k+1] = blocked[k] | req[k];
   end

   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int k = 0; k < int'(N); k++)
         if (grant[k]) idx = IDXW'(k);
   end
endmodule

// File: rtl/mprot_side.sv
module mprot_side
   import mprot_pkg::*;
#(
   parameter bit          IS_DATA   = 1'b0,
   parameter int unsigned AW        = 32,
   parameter int unsigned NREG      = 4,
   parameter int unsigned MIN_SHIFT = 12,
   parameter int unsigned MAX_CODE  = 12,
   parameter int unsigned SZW       = 4,
   parameter int unsigned IDXW      = 2,
   parameter int unsigned SELW      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_dside,
   input  logic [SELW-1:0] cfg_sel,
   input  logic [AW-1:0]   cfg_base,
   input  logic [SZW-1:0]  cfg_size,
   input  cfg_attr_t       cfg_attr,
   input  attr_t           def_attr,
   input  logic            vld,
   input  logic [AW-1:0]   addr,
   input  logic            wr,
   input  logic            user,
   input  logic            spec,
   output logic            ok,
   output logic            stall,
   output logic            fault,
   output logic            hit,
   output logic [IDXW-1:0] idx,
   output attr_t           attr
);
   logic [NREG-1:0] match;
   logic [NREG-1:0] grant;
   logic            any;
   logic [IDXW-1:0] win;
   attr_t           r_attr [NREG];
   logic            side_sel;
   logic            ext_viol;
   verdict_t        vd;

   assign side_sel = cfg_we && (cfg_dside == IS_DATA);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      mprot_region #(
         .AW(AW), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE), .SZW(SZW)
      ) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (side_sel && (cfg_sel == SELW'(k))),
         .base_in (cfg_base),
         .size_in (cfg_size),
         .attr_in (cfg_attr),
         .addr    (addr),
         .match   (match[k]),
         .attr_o  (r_attr[k])
      );
   end

   mprot_prio #(.N(NREG), .IDXW(IDXW)) u_prio (
      .req   (match),
      .grant (grant),
      .any   (any),
      .idx   (win)
   );

   always_comb begin
      attr = def_attr;
      for (int k = 0; k < int'(NREG); k++)
         if (grant[k]) attr = r_attr[k];
   end

   // data side adds write and privilege checks; fetch side has none
   if (IS_DATA) begin : g_data_chk
      assign ext_viol = (wr & attr[AT_RO]) | (user & attr[AT_SV]);

      AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (vld && wr && attr[AT_RO]) |-> fault); // R9
      AST_SV_USER: assert property (@(posedge clk) disable iff (!rst_n)
         (vld && user && attr[AT_SV]) |-> fault); // R10
   end else begin : g_fetch_chk
      logic unused_side;
      assign unused_side = wr ^ user;
      assign ext_viol    = 1'b0;
   end

   always_comb begin
      vd.fault = vld & (~attr[AT_ALLOW] | ext_viol);
      vd.stall = vld & ~vd.fault & spec & ~attr[AT_SPEC];
      vd.ok    = vld & ~vd.fault & ~vd.stall;
   end

   assign ok    = vd.ok;
   assign stall = vd.stall;
   assign fault = vd.fault;
   assign hit   = vld & any;
   assign idx   = (vld & any) ? win : '0;

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> ($countones({ok, stall, fault}) == 1)); // R13
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> !(ok || stall || fault || hit)); // R13
   AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (match[idx] && ((match & ((NREG'(1) << idx) - NREG'(1))) == '0))); // R5
   AST_DENY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !attr[AT_ALLOW]) |-> fault); // R8
   AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && spec && !attr[AT_SPEC] && !fault) |-> stall); // R12
endmodule

// File: rtl/mprot_unit.sv
module mprot_unit
   import mprot_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned NREG      = 4,
   parameter int unsigned MIN_SHIFT = 12,
   parameter int unsigned MAX_CODE  = 12,
   parameter int unsigned SZW       = 4,
   parameter logic [3:0]  DEF_RST   = 4'b0011,
   localparam int unsigned IDXW     = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int unsigned SELW     = $clog2(NREG + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_dside,
   input  logic [SELW-1:0] cfg_sel,
   input  logic [AW-1:0]   cfg_base,
   input  logic [SZW-1:0]  cfg_size,
   input  logic [4:0]      cfg_attr,
   input  logic            i_vld,
   input  logic [AW-1:0]   i_addr,
   input  logic            i_spec,
   output logic            i_ok,
   output logic            i_stall,
   output logic            i_fault,
   output logic            i_hit,
   output logic [IDXW-1:0] i_idx,
   output logic [3:0]      i_attr,
   input  logic            d_vld,
   input  logic [AW-1:0]   d_addr,
   input  logic            d_wr,
   input  logic            d_user,
   input  logic            d_spec,
   output logic            d_ok,
   output logic            d_stall,
   output logic            d_fault,
   output logic            d_hit,
   output logic [IDXW-1:0] d_idx,
   output logic [3:0]      d_attr
);
   if (NREG < 1) begin : g_bad_nreg
      $error("mprot_unit: NREG must be at least 1");
   end
   if (MIN_SHIFT + MAX_CODE >= AW) begin : g_bad_span
      $error("mprot_unit: largest region does not fit the address width");
   end
   if ((1 << SZW) <= MAX_CODE) begin : g_bad_szw
      $error("mprot_unit: SZW too narrow for MAX_CODE");
   end

   attr_t def_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         def_q <= DEF_RST;
      else if (cfg_we && cfg_sel == SELW'(NREG))
         def_q <= cfg_attr[ATW-1:0];
   end

   mprot_side #(
      .IS_DATA(1'b0), .AW(AW), .NREG(NREG), .MIN_SHIFT(MIN_SHIFT),
      .MAX_CODE(MAX_CODE), .SZW(SZW), .IDXW(IDXW), .SELW(SELW)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_dside(cfg_dside), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_attr(cfg_attr),
      .def_attr(def_q),
      .vld(i_vld), .addr(i_addr), .wr(1'b0), .user(1'b0), .spec(i_spec),
      .ok(i_ok), .stall(i_stall), .fault(i_fault),
      .hit(i_hit), .idx(i_idx), .attr(i_attr)
   );

   mprot_side #(
      .IS_DATA(1'b1), .AW(AW), .NREG(NREG), .MIN_SHIFT(MIN_SHIFT),
      .MAX_CODE(MAX_CODE), .SZW(SZW), .IDXW(IDXW), .SELW(SELW)
   ) u_data (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_dside(cfg_dside), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_attr(cfg_attr),
      .def_attr(def_q),
      .vld(d_vld), .addr(d_addr), .wr(d_wr), .user(d_user), .spec(d_spec),
      .ok(d_ok), .stall(d_stall), .fault(d_fault),
      .hit(d_hit), .idx(d_idx), .attr(d_attr)
   );

   AST_DEFAULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SELW'(NREG)) |=> (d_hit || !d_vld || d_attr == $past(cfg_attr[ATW-1:0]))); // R6
endmodule

// File: tb/mprot_unit_bench.sv
`timescale 1ns/1ps
module mprot_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_dside = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_base = '0;
   logic [3:0]  cfg_size = '0;
   logic [4:0]  cfg_attr = '0;
   logic        i_vld = 1'b0, i_spec = 1'b0;
   logic [31:0] i_addr = '0;
   logic        i_ok, i_stall, i_fault, i_hit;
   logic [1:0]  i_idx;
   logic [3:0]  i_attr;
   logic        d_vld = 1'b0, d_wr = 1'b0, d_user = 1'b0, d_spec = 1'b0;
   logic [31:0] d_addr = '0;
   logic        d_ok, d_stall, d_fault, d_hit;
   logic [1:0]  d_idx;
   logic [3:0]  d_attr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mprot_unit u_mprot_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_dside(cfg_dside), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_attr(cfg_attr),
      .i_vld(i_vld), .i_addr(i_addr), .i_spec(i_spec),
      .i_ok(i_ok), .i_stall(i_stall), .i_fault(i_fault),
      .i_hit(i_hit), .i_idx(i_idx), .i_attr(i_attr),
      .d_vld(d_vld), .d_addr(d_addr), .d_wr(d_wr), .d_user(d_user), .d_spec(d_spec),
      .d_ok(d_ok), .d_stall(d_stall), .d_fault(d_fault),
      .d_hit(d_hit), .d_idx(d_idx), .d_attr(d_attr)
   );

   // {addr, wr, user, spec, expected {ok,stall,fault,hit,idx[1:0],attr[3:0]}}
   localparam int NV = 12;
   localparam logic [44:0] VEC [NV] = '{
      {32'h0000_1234, 3'b000, 10'b1_0_0_1_00_0011}, // R5 R2: region 0 wins over region 2
      {32'h0000_2000, 3'b000, 10'b1_0_0_1_10_1011}, // R3 R2: misaligned base of region 2
      {32'h0000_2000, 3'b010, 10'b0_0_1_1_10_1011}, // R10 user to supervisor-only
      {32'h0001_8000, 3'b100, 10'b0_0_1_1_01_0101}, // R9 write to read-only
      {32'h0001_8000, 3'b001, 10'b0_1_0_1_01_0101}, // R12 speculative read stalls
      {32'h0001_8000, 3'b010, 10'b1_0_0_1_01_0101}, // R10 user read allowed
      {32'h0001_8000, 3'b101, 10'b0_0_1_1_01_0101}, // R12 fault beats stall
      {32'h0200_0000, 3'b000, 10'b0_0_1_1_11_0000}, // R8 deny region
      {32'h02FF_FFFC, 3'b000, 10'b0_0_1_1_11_0000}, // R2 top of 16 MB
      {32'h0300_0000, 3'b000, 10'b1_0_0_0_00_0011}, // R6 default entry
      {32'h0000_0FFC, 3'b000, 10'b1_0_0_1_10_1011}, // R2 below 4 KB region
      {32'h0000_2000, 3'b001, 10'b1_0_0_1_10_1011}  // R12 speculation allowed
   };

   task automatic cmp(input string tag, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic dside, input logic [2:0] sel, input logic [31:0] base,
                            input logic [3:0] sz, input logic [4:0] at);
      @(negedge clk);
      cfg_we = 1'b1; cfg_dside = dside; cfg_sel = sel;
      cfg_base = base; cfg_size = sz; cfg_attr = at;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic dchk(input string tag, input logic [31:0] a, input logic [2:0] wus,
                       input logic [9:0] exp);
      @(negedge clk);
      d_vld = 1'b1; d_addr = a; {d_wr, d_user, d_spec} = wus;
      #1 cmp(tag, {d_ok, d_stall, d_fault, d_hit, d_idx, d_attr}, exp);
   endtask

   task automatic ichk(input string tag, input logic [31:0] a, input logic sp,
                       input logic [9:0] exp);
      @(negedge clk);
      i_vld = 1'b1; i_addr = a; i_spec = sp;
      #1 cmp(tag, {i_ok, i_stall, i_fault, i_hit, i_idx, i_attr}, exp);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state on both sides
      dchk("R1 data after reset", 32'h0000_1234, 3'b000, 10'b1_0_0_0_00_0011);
      ichk("R1 fetch after reset", 32'h1234_5678, 1'b1, 10'b1_0_0_0_00_0011);

      // R13: idle access reports nothing
      @(negedge clk);
      d_vld = 1'b0; i_vld = 1'b0;
      #1 cmp("R13 idle", {d_ok, d_stall, d_fault, d_hit, i_ok, i_stall, i_fault, i_hit, 2'b00},
             10'b0);

      // data regions
      cfg_write(1'b1, 3'd0, 32'h0000_1000, 4'd0,  5'h13);
      cfg_write(1'b1, 3'd1, 32'h0001_0000, 4'd4,  5'h15);
      cfg_write(1'b1, 3'd2, 32'h0001_0000, 4'd8,  5'h1B);
      cfg_write(1'b1, 3'd3, 32'h0200_0000, 4'd12, 5'h10);

      for (int v = 0; v < NV; v++) begin
         dchk($sformatf("vector %0d", v), VEC[v][44:13], VEC[v][12:10], VEC[v][9:0]);
      end

      // R7: data regions do not reach the fetch side
      ichk("R7 fetch ignores data regions", 32'h0000_1234, 1'b0, 10'b1_0_0_0_00_0011);

      // R11 / R12 on fetch side
      cfg_write(1'b0, 3'd0, 32'h0001_0000, 4'd4, 5'h1D);
      ichk("R11 fetch no ro/sv check", 32'h0001_8000, 1'b0, 10'b1_0_0_1_00_1101);
      ichk("R12 fetch speculative stall", 32'h0001_8000, 1'b1, 10'b0_1_0_1_00_1101);
      dchk("R7 data unchanged by fetch write", 32'h0001_8000, 3'b000, 10'b1_0_0_1_01_0101);

      // R14 and R3: write timing, misaligned base
      @(negedge clk);
      cfg_we = 1'b1; cfg_dside = 1'b0; cfg_sel = 3'd1;
      cfg_base = 32'h0040_0ABC; cfg_size = 4'd4; cfg_attr = 5'h13;
      i_vld = 1'b1; i_addr = 32'h0040_0000; i_spec = 1'b0;
      #1 cmp("R14 before edge", {i_ok, i_stall, i_fault, i_hit, i_idx, i_attr}, 10'b1_0_0_0_00_0011);
      @(posedge clk);
      #1 cmp("R14 after edge", {i_ok, i_stall, i_fault, i_hit, i_idx, i_attr}, 10'b1_0_0_1_01_0011);
      cfg_we = 1'b0;
      ichk("R3 outside aligned region", 32'h0041_0000, 1'b0, 10'b1_0_0_0_00_0011);

      // R2: size code clamp
      cfg_write(1'b0, 3'd2, 32'h1000_0000, 4'd15, 5'h13);
      ichk("R2 clamp inside", 32'h10FF_FFFF, 1'b0, 10'b1_0_0_1_10_0011);
      ichk("R2 clamp outside", 32'h1100_0000, 1'b0, 10'b1_0_0_0_00_0011);

      // R4: disabled region
      cfg_write(1'b1, 3'd0, 32'h0000_1000, 4'd0, 5'h03);
      dchk("R4 disabled region skipped", 32'h0000_1234, 3'b000, 10'b1_0_0_1_10_1011);

      // R6: shared default entry
      cfg_write(1'b1, 3'd4, 32'h0, 4'd0, 5'h00);
      dchk("R6 data default deny", 32'h0300_0000, 3'b000, 10'b0_0_1_0_00_0000);
      ichk("R6 fetch default deny", 32'h2000_0000, 1'b0, 10'b0_0_1_0_00_0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule